// File: doc/BRIEF.md
# Slaved Line Bit and Frame Timing Generator

This block divides a fast master clock into a transmit bit strobe. It counts those bits into fixed-length line frames. It also keeps the frame phase-locked to a host-side frame sync pulse. With the defaults, the master clock is 7.68 MHz, the divide ratio is 40 (192 kHz bit rate) and a frame holds 48 bits (4 kHz frame rate). The frame marker is high during bit position 0. Its falling edge, where bit position 1 begins, is the point that is held aligned to the external sync.

Alignment is kept by a simple digital loop that only ever moves by whole master-clock periods. Each accepted sync pulse is classed as early, late or aligned against the internal frame marker edge. The result is applied to the last bit period of a frame, which is stretched or shrunk by one master period. The bit phase therefore walks toward the sync by at most one period per frame. Without sync pulses the generator free-runs at the nominal ratio.

For fixed-timing receive operation, the same counters also produce a receive sampling strobe. It lands a fixed number of master periods ahead of each transmit bit edge, pulled later by a small programmable delay that covers transformer, filter and driver latency. The block also gives an uplink bit index that lags the transmit index by two positions.

Top module: `tx_timing_gen`

## Requirements
- R1: While `rst_n` is low, `bit_pos` is 0, `frame_mark` is 1 and `rx_stb` is 0.
- R2: With no sync pulses, `bit_stb` is high for one cycle every DIV cycles, and at each strobe `bit_pos` moves to (previous + 1) mod BITS.
- R3: `frame_mark` is high for exactly DIV consecutive cycles, covering bit position 0. It falls in the cycle where `bit_stb` is high and `bit_pos` is 1.
- R4: Every bit period lasts DIV-1, DIV or DIV+1 master cycles.
- R5: A bit period other than DIV cycles occurs only as the last bit period of a frame (`bit_pos` = BITS-1), so a frame carries at most one correction.
- R6: A sync pulse within half a frame after the marker's falling edge lengthens a period. An earlier one shortens a period, and one in the falling-edge cycle changes nothing. From frame to frame the alignment error never grows and shrinks by at most one cycle. Under a steady sync train it reaches zero, with the sync pulse in the first low cycle of `frame_mark`.
- R7: `rx_stb` is high for exactly one cycle in every bit period, RX_ADV - `rx_dly` cycles before the next `bit_stb` (RX_ADV = 5 by default). This holds also in stretched and shrunk periods.
- R8: `rx_pos` equals (`bit_pos` - 2) mod BITS at all times.
- R9: An `rx_dly` value above RX_ADV-1 acts as RX_ADV-1, putting `rx_stb` one cycle before the bit edge; `rx_dly` is changed only while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | One-cycle host frame sync pulse |
| rx_dly | input | DLY_W | Receive sampling delay in master cycles |
| bit_stb | output | 1 | First cycle of each transmit bit period |
| bit_pos | output | $clog2(BITS) | Transmit bit index within the frame |
| frame_mark | output | 1 | High during bit position 0 |
| rx_stb | output | 1 | Receive sampling strobe |
| rx_pos | output | $clog2(BITS) | Uplink bit index, two behind `bit_pos` |

## Verification
The bench sweeps every starting offset between the free-running frame and a sync train. It follows the alignment error from one frame to the next. A loop that steers the wrong way would make the error grow. A loop that reacts twice per frame would skip it by two, and one that reacts in the wrong bit would produce odd-length periods outside the final bit. The receive strobe is timed against the following bit edge in every delay setting, including clamped ones and in corrected periods. A strobe placed from the nominal count instead of the live one would be off by one cycle there. The lagging index is compared at every strobe, which catches a wrong wrap near position 0.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_LONG  = 2'd1,
    ADJ_SHORT = 2'd2
  } adj_e;

  // last phase value of a bit period for a given correction
  function automatic int unsigned period_term(input int unsigned div, input adj_e a);
    case (a)
      ADJ_LONG:  return div;
      ADJ_SHORT: return div - 2;
      default:   return div - 1;
    endcase
  endfunction

  // master-cycle distance from the marker falling edge, modulo one frame
  function automatic int unsigned frame_offset(input int unsigned pos, input int unsigned div,
                                               input int unsigned frame);
    return (pos + frame - div) % frame;
  endfunction

  function automatic adj_e pick_adj(input int unsigned off, input int unsigned frame);
    if (off == 0) return ADJ_NONE;
    else if (off <= frame / 2) return ADJ_LONG;
    else return ADJ_SHORT;
  endfunction

  function automatic int unsigned clamp_dly(input int unsigned dly, input int unsigned adv);
    return (dly > adv - 1) ? adv - 1 : dly;
  endfunction

  // phase value at which the receive strobe fires
  function automatic int unsigned rx_point(input int unsigned term, input int unsigned adv,
                                           input int unsigned dly);
    return term + 1 - adv + dly;
  endfunction

  function automatic int unsigned lag_pos(input int unsigned pos, input int unsigned lag,
                                          input int unsigned bits);
    return (pos + bits - (lag % bits)) % bits;
  endfunction

endpackage

// File: rtl/tmg_bit_div.sv
module tmg_bit_div
  import tmg_pkg::*;
#(
  parameter  int DIV  = 40,
  localparam int PH_W = $clog2(DIV + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  adj_e            adj_next,
  input  logic            load_slot,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] term,
  output logic            wrap,
  output logic            bit_stb,
  output adj_e            adj_cur
);

  always_comb begin
    term    = PH_W'(period_term(32'(DIV), adj_cur));
    wrap    = (ph == term);
    bit_stb = (ph == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      adj_cur <= ADJ_NONE;
    end else if (wrap) begin
      ph      <= '0;
      adj_cur <= load_slot ? adj_next : ADJ_NONE;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // R4: a bit period ends only one cycle away from the nominal length
  assert_period_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> ((32'(ph) + 2 >= 32'(DIV)) && (32'(ph) <= 32'(DIV))));

endmodule

// File: rtl/tmg_frame_cnt.sv
module tmg_frame_cnt
  import tmg_pkg::*;
#(
  parameter  int BITS = 48,
  parameter  int LAG  = 2,
  localparam int BP_W = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap,
  output logic [BP_W-1:0] bit_pos,
  output logic [BP_W-1:0] rx_pos,
  output logic            frm_mark,
  output logic            slot,
  output logic            frame_wrap
);

  logic last_bit;

  always_comb begin
    last_bit   = (bit_pos == BP_W'(BITS - 1));
    frm_mark   = (bit_pos == '0);
    slot       = wrap && (bit_pos == BP_W'(BITS - 2));
    frame_wrap = wrap && last_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_pos <= '0;
    else if (wrap) bit_pos <= last_bit ? '0 : bit_pos + 1'b1;
  end

  generate
    if (LAG % BITS == 0) begin : g_nolag
      assign rx_pos = bit_pos;
    end else begin : g_lag
      always_comb rx_pos = BP_W'(lag_pos(32'(bit_pos), 32'(LAG), 32'(BITS)));
    end
  endgenerate

  // R8: uplink index steps with the transmit index and wraps the same way
  assert_rx_pos_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (rx_pos == BP_W'((32'($past(rx_pos)) + 1) % 32'(BITS))));

endmodule

// File: rtl/tmg_phase_det.sv
module tmg_phase_det
  import tmg_pkg::*;
#(
  parameter int DIV  = 40,
  parameter int BITS = 48,
  parameter int PH_W = 6,
  parameter int BP_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_in,
  input  logic [PH_W-1:0] ph,
  input  logic [BP_W-1:0] bit_pos,
  input  logic            frame_wrap,
  input  logic            consume,
  output adj_e            pending
);

  localparam int unsigned FRAME = DIV * BITS;

  int unsigned pos_now;
  int unsigned off_now;
  adj_e        dir_now;
  logic        used;
  logic        accept;

  always_comb begin
    pos_now = 32'(bit_pos) * 32'(DIV) + 32'(ph);
    off_now = frame_offset(pos_now, 32'(DIV), FRAME);
    dir_now = pick_adj(off_now, FRAME);
    accept  = sync_in && !used;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used    <= 1'b0;
      pending <= ADJ_NONE;
    end else begin
      used <= frame_wrap ? 1'b0 : (used | accept);
      if (consume) pending <= accept ? dir_now : ADJ_NONE;
      else if (accept) pending <= dir_now;
    end
  end

  // R6: a decision waits untouched until the frame's correction slot
  assert_pending_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending != ADJ_NONE) && !consume && !accept) |=> (pending == $past(pending)));

endmodule

// File: rtl/tmg_rx_strobe.sv
module tmg_rx_strobe
  import tmg_pkg::*;
#(
  parameter int DIV   = 40,
  parameter int ADV   = 5,
  parameter int DLY_W = 3,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph,
  input  logic [PH_W-1:0]  term,
  input  logic             bit_stb,
  input  logic [DLY_W-1:0] dly,
  output logic             rx_stb
);

  localparam int GAP_W = PH_W + 1;

  int unsigned      dly_c;
  logic [GAP_W-1:0] gap;
  logic             seen;

  always_comb begin
    dly_c  = clamp_dly(32'(dly), 32'(ADV));
    rx_stb = (ph == PH_W'(rx_point(32'(term), 32'(ADV), dly_c)));
  end

  // checker state: cycles since the last strobe, strobe seen this period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      gap  <= rx_stb ? GAP_W'(1) : gap + 1'b1;
      if (rx_stb) seen <= 1'b1;
      else if (bit_stb) seen <= 1'b0;
    end
  end

  // R7: one strobe per bit period
  assert_rx_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> !seen);

  // R7 / R9: fixed advance ahead of the next bit edge, delay clamped
  assert_rx_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && seen) |-> (gap == GAP_W'(32'(ADV) - dly_c)));

endmodule

// File: rtl/tx_timing_gen.sv
module tx_timing_gen
  import tmg_pkg::*;
#(
  parameter  int DIV    = 40,
  parameter  int BITS   = 48,
  parameter  int RX_ADV = 5,
  parameter  int UP_LAG = 2,
  parameter  int DLY_W  = 3,
  localparam int BP_W   = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [DLY_W-1:0] rx_dly,
  output logic             bit_stb,
  output logic [BP_W-1:0]  bit_pos,
  output logic             frame_mark,
  output logic             rx_stb,
  output logic [BP_W-1:0]  rx_pos
);

  localparam int PH_W = $clog2(DIV + 1);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] term;
  logic            wrap;
  logic            slot;
  logic            frame_wrap;
  adj_e            adj_cur;
  adj_e            pending;

  tmg_bit_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .adj_next(pending), .load_slot(slot),
    .ph(ph), .term(term), .wrap(wrap), .bit_stb(bit_stb), .adj_cur(adj_cur)
  );

  tmg_frame_cnt #(.BITS(BITS), .LAG(UP_LAG)) u_frm (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .bit_pos(bit_pos), .rx_pos(rx_pos),
    .frm_mark(frame_mark), .slot(slot), .frame_wrap(frame_wrap)
  );

  tmg_phase_det #(.DIV(DIV), .BITS(BITS), .PH_W(PH_W), .BP_W(BP_W)) u_pd (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .ph(ph), .bit_pos(bit_pos),
    .frame_wrap(frame_wrap), .consume(slot), .pending(pending)
  );

  tmg_rx_strobe #(.DIV(DIV), .ADV(RX_ADV), .DLY_W(DLY_W), .PH_W(PH_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ph(ph), .term(term), .bit_stb(bit_stb),
    .dly(rx_dly), .rx_stb(rx_stb)
  );

  // R5: an odd-length period is always the last one of its frame
  assert_adj_last_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_cur != ADJ_NONE) |-> (bit_pos == BP_W'(BITS - 1)));

  // R3: marker drops exactly on the strobe that opens bit position 1
  assert_marker_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_mark) |-> (bit_stb && (bit_pos == BP_W'(1))));

endmodule

// File: tb/tx_timing_gen_tb_top.sv
module tx_timing_gen_tb_top;
  localparam int DIV = 8, BITS = 6, ADV = 5, LAG = 2, DLY_W = 3;
  localparam int FRAME = DIV * BITS, BP_W = $clog2(BITS), NF = 40;

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
  logic [DLY_W-1:0] rx_dly = '0;
  logic bit_stb, frame_mark, rx_stb;
  logic [BP_W-1:0] bit_pos, rx_pos;

  tx_timing_gen #(.DIV(DIV), .BITS(BITS), .RX_ADV(ADV), .UP_LAG(LAG), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rx_dly(rx_dly), .bit_stb(bit_stb),
    .bit_pos(bit_pos), .frame_mark(frame_mark), .rx_stb(rx_stb), .rx_pos(rx_pos)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  bit free_mode = 0, lock_on = 0, sync_started = 0;
  bit have_stb = 0, have_rise = 0, have_mag = 0, prev_mark = 1;
  longint last_stb, rx_cyc, rise_cyc, t0;
  int prev_pos, rx_cnt, exp_gap, cur_dly, prev_mag, last_mag, len, mag, r;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1 reset state
      chk(bit_pos == 0, "R1", "bit_pos in reset", bit_pos, 0);
      chk(frame_mark == 1, "R1", "frame_mark in reset", frame_mark, 1);
      chk(rx_stb == 0, "R1", "rx_stb in reset", rx_stb, 0);
      have_stb = 0; have_rise = 0; rx_cnt = 0; prev_mark = 1;
    end else begin
      if (rx_stb) begin
        rx_cnt++; rx_cyc = cyc;
        chk(int'(rx_pos) == (int'(bit_pos) + BITS - LAG) % BITS, "R8", "rx_pos",
            rx_pos, (int'(bit_pos) + BITS - LAG) % BITS);
      end
      if (bit_stb) begin
        if (have_stb) begin
          len = int'(cyc - last_stb);
          chk(len >= DIV - 1 && len <= DIV + 1, "R4", "bit period length", len, DIV);
          if (free_mode) chk(len == DIV, "R2", "free-run period", len, DIV);
          if (len != DIV) chk(prev_pos == BITS - 1, "R5", "corrected bit position", prev_pos, BITS - 1);
          chk(int'(bit_pos) == (prev_pos + 1) % BITS, "R2", "bit_pos step", bit_pos,
              (prev_pos + 1) % BITS);
          chk(rx_cnt == 1, "R7", "rx strobes per period", rx_cnt, 1);
          if (rx_cnt == 1)
            chk(cyc - rx_cyc == longint'(exp_gap), (cur_dly >= ADV) ? "R9" : "R7",
                "rx strobe advance", cyc - rx_cyc, exp_gap);
        end
        have_stb = 1; last_stb = cyc; prev_pos = int'(bit_pos); rx_cnt = 0;
      end
      if (frame_mark && !prev_mark) begin
        have_rise = 1; rise_cyc = cyc;
      end
      if (!frame_mark && prev_mark) begin
        chk(bit_stb && bit_pos == 1, "R3", "marker fall position", bit_pos, 1);
        if (have_rise) chk(cyc - rise_cyc == DIV, "R3", "marker width", cyc - rise_cyc, DIV);
        if (lock_on && sync_started && cyc >= t0) begin
          r = int'((cyc - t0) % FRAME);
          mag = (r < FRAME - r) ? r : FRAME - r;
          if (have_mag)
            chk(mag <= prev_mag && prev_mag - mag <= 1, "R6", "alignment error step", mag, prev_mag);
          prev_mag = mag; last_mag = mag; have_mag = 1;
        end
      end
      prev_mark = frame_mark;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic set_dly(input int d);
    cur_dly = d;
    rx_dly = DLY_W'(d);
    exp_gap = ADV - ((d > ADV - 1) ? ADV - 1 : d);
  endtask

  task automatic run_lock(input int s);
    set_dly(s % 8);
    free_mode = 0; lock_on = 1; have_mag = 0; sync_started = 0; last_mag = -1;
    do_reset();
    repeat (s) @(posedge clk);
    for (int n = 0; n < NF; n++) begin
      @(posedge clk); #1 sync_in = 1'b1;
      if (n == 0) begin t0 = cyc; sync_started = 1; end
      @(posedge clk); #1 sync_in = 1'b0;
      repeat (FRAME - 2) @(posedge clk);
    end
    repeat (FRAME) @(posedge clk);
    // R6 final lock: sync lands in the marker's first low cycle
    chk(have_mag && last_mag == 0, "R6", "locked error", last_mag, 0);
    lock_on = 0; sync_started = 0;
  endtask

  initial begin
    set_dly(0);
    repeat (2) @(posedge clk);
    // R2, R3, R7, R9: free-run across every delay code
    for (int d = 0; d < (1 << DLY_W); d++) begin
      set_dly(d);
      free_mode = 1;
      do_reset();
      repeat (2 * FRAME + 4) @(posedge clk);
    end
    free_mode = 0;
    // R4, R5, R6: every starting offset against a steady sync train
    for (int s = 0; s < FRAME; s++) run_lock(s);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule